// File: doc/BRIEF.md
# Strip Readout Common-Mode and Zero-Suppression Processor

This block takes one event of digitised samples from a silicon strip front-end, with one unsigned ADC code per channel, all channels presented in parallel. It removes a programmable per-channel offset (pedestal) from each sample. It then estimates the common-mode level as the mean of the offset-corrected values and removes that level from every channel. Last, it drops every channel whose corrected result is too small. The results are signed, so hits of either polarity survive.

Surviving channels leave one per cycle on a valid/ready stream, in ascending channel order, each tagged with its channel index. A marker beat closes every event, including an event that produced no hits. Pedestals are loaded through an addressed write port and the threshold through its own write port. Both are sampled when an event is accepted, so a write never changes an event that is already in flight.

Back-pressure works as follows. The input side accepts an event only while the block is idle (`ev_ready` high). `ev_ready` stays low from acceptance until the end-of-event beat has been taken. On the output side a beat transfers on a clock edge where `out_valid` and `out_ready` are both high. Once `out_valid` is raised, it and all output fields stay unchanged until the transfer. `out_valid` never depends on `out_ready`.

Top module: `strip_cm_processor`

## Requirements
- R1: An event on `ev_raw` is accepted on a rising edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is high only when idle. It is low in the cycle after acceptance and remains low until the end-of-event beat transfers.
- R2: Each channel's corrected value is raw code (unsigned) minus pedestal (signed 8-bit), saturated to the signed 8-bit range [-128, 127] instead of wrapping.
- R3: The common-mode mean is the sum of all corrected values arithmetically shifted right by log2(channel count). This rounds toward negative infinity, so a sum of -1 gives a mean of -1.
- R4: Each channel's final value is its corrected value minus the mean, saturated to [-128, 127].
- R5: A channel is forwarded if and only if the absolute value of its final value is greater than or equal to the 7-bit threshold. A threshold of 0 forwards every channel.
- R6: Each forwarded channel produces exactly one beat with `out_eoe`=0, `out_idx` = channel index and `out_val` = final value in two's complement. Beats come in strictly ascending channel order.
- R7: After the last hit beat of an event, one beat with `out_eoe`=1 is sent. It is sent even when no channel passes. After it transfers, the block is idle again.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_eoe`, `out_idx` and `out_val` hold their values.
- R9: A pedestal or threshold write takes effect from the next accepted event. A write made in the same cycle as acceptance, or while an event is being processed, does not alter that event.
- R10: After reset, `ev_ready` is high, `out_valid` is low, all pedestals are 0 and the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event present on `ev_raw` |
| ev_ready | output | 1 | Block idle, event can be accepted |
| ev_raw | input | NCH*ADC_W (768) | Raw codes, channel k in bits [k*ADC_W +: ADC_W] |
| ped_we | input | 1 | Pedestal write strobe |
| ped_addr | input | IDX_W (7) | Pedestal channel address |
| ped_data | input | VAL_W (8) | Signed pedestal value |
| thr_we | input | 1 | Threshold write strobe |
| thr_data | input | TH_W (7) | Unsigned threshold value |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_eoe | output | 1 | Beat is the end-of-event marker |
| out_idx | output | IDX_W (7) | Channel index of a hit beat |
| out_val | output | VAL_W (8) | Signed final value of a hit beat |

## Verification
The bench first sets up a sample pattern whose total is -1. If the mean were truncated toward zero, the wrong set of channels would be reported. It also drives channels into both saturation limits, where a wrapping subtractor would flip the sign and move the hit to or from the output. A full threshold sweep checks the boundary at equality: an off-by-one comparator drops or adds exactly the channels whose magnitude equals the threshold. Separate events cover an empty result, which needs the lone end-of-event beat; writes made at acceptance and during the scan, which must not leak into the current event; and irregular back-pressure, which would expose lost, repeated or reordered beats.

// File: rtl/strip_dsp_pkg.sv
package strip_dsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAN = 2'd1,
    ST_SCAN = 2'd2,
    ST_EOE  = 2'd3
  } proc_state_t;
endpackage

// File: rtl/ped_regfile.sv
module ped_regfile #(
  parameter int NCH   = 128,
  parameter int VAL_W = 8,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       addr,
  input  logic [VAL_W-1:0]       wdata,
  output logic [NCH*VAL_W-1:0]   ped_flat
);
  for (genvar k = 0; k < NCH; k++) begin : g_ped
    logic [VAL_W-1:0] ped_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ped_q <= '0;
      else if (we && (addr == IDX_W'(k))) ped_q <= wdata;
    end
    assign ped_flat[k*VAL_W +: VAL_W] = ped_q;
  end
endmodule

// File: rtl/cm_mean.sv
module cm_mean #(
  parameter int NCH   = 128,
  parameter int VAL_W = 8,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH*VAL_W-1:0] corr_flat,
  output logic [VAL_W-1:0]     mean
);
  localparam int SUM_W = VAL_W + IDX_W;

  logic signed [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int k = 0; k < NCH; k++) begin
      total = total + $signed({{IDX_W{corr_flat[k*VAL_W + VAL_W-1]}},
                               corr_flat[k*VAL_W +: VAL_W]});
    end
  end

  // dropping the low bits of a two's complement sum floors it
  assign mean = total[SUM_W-1:IDX_W];
endmodule

// File: rtl/hit_select.sv
module hit_select #(
  parameter int NCH   = 128,
  parameter int VAL_W = 8,
  parameter int TH_W  = 7,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH*VAL_W-1:0] corr_flat,
  input  logic [VAL_W-1:0]     mean,
  input  logic [IDX_W-1:0]     idx,
  input  logic [TH_W-1:0]      thr,
  output logic [VAL_W-1:0]     final_val,
  output logic                 pass
);
  logic [VAL_W-1:0] chan;
  logic [VAL_W:0]   diff;
  logic [VAL_W:0]   mag;

  assign chan = corr_flat[idx*VAL_W +: VAL_W];
  assign diff = {chan[VAL_W-1], chan} - {mean[VAL_W-1], mean};

  always_comb begin
    if (diff[VAL_W] != diff[VAL_W-1])
      final_val = diff[VAL_W] ? {1'b1, {(VAL_W-1){1'b0}}} : {1'b0, {(VAL_W-1){1'b1}}};
    else
      final_val = diff[VAL_W-1:0];
    mag  = final_val[VAL_W-1] ? (~{1'b1, final_val} + 1'b1) : {1'b0, final_val};
    pass = (mag >= (VAL_W+1)'(thr));
  end
endmodule

// File: rtl/strip_cm_processor.sv
module strip_cm_processor
  import strip_dsp_pkg::*;
#(
  parameter int NCH   = 128,
  parameter int ADC_W = 6,
  parameter int VAL_W = 8,
  parameter int TH_W  = 7,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_valid,
  output logic                   ev_ready,
  input  logic [NCH*ADC_W-1:0]   ev_raw,
  input  logic                   ped_we,
  input  logic [IDX_W-1:0]       ped_addr,
  input  logic [VAL_W-1:0]       ped_data,
  input  logic                   thr_we,
  input  logic [TH_W-1:0]        thr_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_eoe,
  output logic [IDX_W-1:0]       out_idx,
  output logic [VAL_W-1:0]       out_val
);
  localparam int DW = VAL_W + 2;

  proc_state_t            state;
  logic [NCH*VAL_W-1:0]   ped_flat;
  logic [NCH*VAL_W-1:0]   corr_d;
  logic [NCH*VAL_W-1:0]   corr_q;
  logic [VAL_W-1:0]       mean_d;
  logic [VAL_W-1:0]       mean_q;
  logic [TH_W-1:0]        thr_reg;
  logic [TH_W-1:0]        thr_q;
  logic [IDX_W-1:0]       idx_q;
  logic [VAL_W-1:0]       sel_val;
  logic                   sel_pass;
  logic                   accept;

  ped_regfile #(.NCH(NCH), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_ped (
    .clk(clk), .rst_n(rst_n), .we(ped_we), .addr(ped_addr),
    .wdata(ped_data), .ped_flat(ped_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_reg <= '0;
    else if (thr_we) thr_reg <= thr_data;
  end

  // pedestal removal with saturation, one subtractor per channel
  for (genvar k = 0; k < NCH; k++) begin : g_corr
    logic [DW-1:0] raw_x;
    logic [DW-1:0] ped_x;
    logic [DW-1:0] dif;
    assign raw_x = DW'(ev_raw[k*ADC_W +: ADC_W]);
    assign ped_x = {{(DW-VAL_W){ped_flat[k*VAL_W + VAL_W-1]}}, ped_flat[k*VAL_W +: VAL_W]};
    assign dif   = raw_x - ped_x;
    always_comb begin
      if (dif[DW-1:VAL_W-1] == '0 || dif[DW-1:VAL_W-1] == '1)
        corr_d[k*VAL_W +: VAL_W] = dif[VAL_W-1:0];
      else if (dif[DW-1])
        corr_d[k*VAL_W +: VAL_W] = {1'b1, {(VAL_W-1){1'b0}}};
      else
        corr_d[k*VAL_W +: VAL_W] = {1'b0, {(VAL_W-1){1'b1}}};
    end
  end

  cm_mean #(.NCH(NCH), .VAL_W(VAL_W), .IDX_W(IDX_W)) u_mean (
    .corr_flat(corr_q), .mean(mean_d)
  );

  hit_select #(.NCH(NCH), .VAL_W(VAL_W), .TH_W(TH_W), .IDX_W(IDX_W)) u_sel (
    .corr_flat(corr_q), .mean(mean_q), .idx(idx_q), .thr(thr_q),
    .final_val(sel_val), .pass(sel_pass)
  );

  assign ev_ready = (state == ST_IDLE);
  assign accept   = ev_valid && ev_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      corr_q <= '0;
      mean_q <= '0;
      thr_q  <= '0;
      idx_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          corr_q <= corr_d;
          thr_q  <= thr_reg;
          state  <= ST_MEAN;
        end
        ST_MEAN: begin
          mean_q <= mean_d;
          idx_q  <= '0;
          state  <= ST_SCAN;
        end
        ST_SCAN: if (!sel_pass || out_ready) begin
          if (idx_q == IDX_W'(NCH-1)) state <= ST_EOE;
          else idx_q <= idx_q + 1'b1;
        end
        ST_EOE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = ((state == ST_SCAN) && sel_pass) || (state == ST_EOE);
  assign out_eoe   = (state == ST_EOE);
  assign out_idx   = (state == ST_SCAN) ? idx_q : '0;
  assign out_val   = (state == ST_SCAN) ? sel_val : '0;
endmodule

// File: rtl/strip_cm_checker.sv
module strip_cm_checker #(
  parameter int VAL_W = 8,
  parameter int TH_W  = 7,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_eoe,
  input logic [IDX_W-1:0] out_idx,
  input logic [VAL_W-1:0] out_val,
  input logic [TH_W-1:0]  thr_q
);
  logic [VAL_W:0] mag;
  assign mag = out_val[VAL_W-1] ? (~{1'b1, out_val} + 1'b1) : {1'b0, out_val};

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> !ev_ready);

  a_r1_no_accept_while_streaming: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ev_ready);

  a_r5_hit_meets_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eoe) |-> (mag >= (VAL_W+1)'(thr_q)));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eoe) |=>
      (!out_valid || out_eoe || (out_idx > $past(out_idx))));

  a_r7_idle_after_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eoe) |=> (ev_ready && !out_valid));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_eoe) && $stable(out_idx) && $stable(out_val)));
endmodule

bind strip_cm_processor strip_cm_checker #(.VAL_W(VAL_W), .TH_W(TH_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_eoe(out_eoe),
  .out_idx(out_idx), .out_val(out_val), .thr_q(thr_q)
);

// File: tb/strip_cm_processor_test.sv
module strip_cm_processor_test;
  localparam int NCH = 128, ADC_W = 6, VAL_W = 8, TH_W = 7, IDX_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_ready;
  logic [NCH*ADC_W-1:0] ev_raw = '0;
  logic ped_we = 1'b0, thr_we = 1'b0;
  logic [IDX_W-1:0] ped_addr = '0;
  logic [VAL_W-1:0] ped_data = '0;
  logic [TH_W-1:0] thr_data = '0;
  logic out_valid, out_ready = 1'b0, out_eoe;
  logic [IDX_W-1:0] out_idx;
  logic [VAL_W-1:0] out_val;

  int n_checks = 0, n_fail = 0, cycles = 0;
  int raw_m[NCH], ped_m[NCH], thr_m = 0;
  int exp_idx[$], exp_val[$];

  always #4 clk = ~clk;

  strip_cm_processor uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_raw(ev_raw), .ped_we(ped_we), .ped_addr(ped_addr), .ped_data(ped_data),
    .thr_we(thr_we), .thr_data(thr_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_eoe(out_eoe), .out_idx(out_idx), .out_val(out_val)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sat8(input int x);
    if (x > 127) return 127;
    if (x < -128) return -128;
    return x;
  endfunction

  function automatic int sval(input logic [VAL_W-1:0] v);
    return int'($signed(v));
  endfunction

  // expected hit list from the requirements (R2..R5)
  task automatic build_expected();
    int c[NCH];
    int sum = 0, mean, f;
    exp_idx.delete(); exp_val.delete();
    for (int k = 0; k < NCH; k++) begin
      c[k] = sat8(raw_m[k] - ped_m[k]);
      sum += c[k];
    end
    mean = sum >>> 7;
    for (int k = 0; k < NCH; k++) begin
      f = sat8(c[k] - mean);
      if ((f < 0 ? -f : f) >= thr_m) begin
        exp_idx.push_back(k); exp_val.push_back(f);
      end
    end
  endtask

  task automatic write_ped(input int ch, input int v);
    @(negedge clk);
    ped_we = 1'b1; ped_addr = IDX_W'(ch); ped_data = VAL_W'(v);
    @(negedge clk);
    ped_we = 1'b0;
    ped_m[ch] = v;
  endtask

  task automatic write_thr(input int v);
    @(negedge clk);
    thr_we = 1'b1; thr_data = TH_W'(v);
    @(negedge clk);
    thr_we = 1'b0;
    thr_m = v;
  endtask

  // wmode: 0 none, 1 write at the acceptance edge, 2 write during the scan
  task automatic run_event(input int stall, input int wmode, input int wch,
                           input int wped, input int wthr, input string req);
    int got = 0, cyc = 0;
    bit done = 0, r, prev_stall = 0;
    int prev_idx = 0, prev_val = 0;
    build_expected();
    for (int k = 0; k < NCH; k++) ev_raw[k*ADC_W +: ADC_W] = ADC_W'(raw_m[k]);
    @(negedge clk);
    check(ev_ready === 1'b1, "R1 idle ready", int'(ev_ready), 1);
    ev_valid = 1'b1;
    if (wmode == 1) begin
      ped_we = 1'b1; ped_addr = IDX_W'(wch); ped_data = VAL_W'(wped);
      thr_we = 1'b1; thr_data = TH_W'(wthr);
    end
    while (!done && cycles < 150000) begin
      @(negedge clk);
      ev_valid = 1'b0;
      cyc++;
      ped_we = 1'b0; thr_we = 1'b0;
      if (wmode == 2 && cyc == 3) begin
        ped_we = 1'b1; ped_addr = IDX_W'(wch); ped_data = VAL_W'(wped);
        thr_we = 1'b1; thr_data = TH_W'(wthr);
      end
      if (cyc == 1) check(ev_ready === 1'b0, "R1 busy after accept", int'(ev_ready), 0);
      if (prev_stall) begin
        check(out_valid && !out_eoe && out_idx == IDX_W'(prev_idx) && sval(out_val) == prev_val,
              "R8 held while stalled", int'(out_idx), prev_idx);
      end
      r = (stall == 0) ? 1'b1 : (((cyc * 7 + 3) % stall) != 0);
      out_ready = r;
      prev_stall = out_valid && !out_eoe && !r;
      prev_idx = int'(out_idx); prev_val = sval(out_val);
      if (out_valid && r) begin
        if (out_eoe) begin
          check(got == exp_idx.size(), {req, " R7 hit count at marker"}, got, exp_idx.size());
          done = 1;
        end else if (got >= exp_idx.size()) begin
          check(0, {req, " R6 extra beat"}, int'(out_idx), -1);
          got++;
        end else begin
          check(int'(out_idx) == exp_idx[got], {req, " R6 index"}, int'(out_idx), exp_idx[got]);
          check(sval(out_val) == exp_val[got], {req, " R4 value"}, sval(out_val), exp_val[got]);
          got++;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(ev_ready === 1'b1 && out_valid === 1'b0, "R7 idle after marker", int'(ev_ready), 1);
    if (wmode != 0) begin
      ped_m[wch] = wped; thr_m = wthr;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles == 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) begin raw_m[k] = 0; ped_m[k] = 0; end
    repeat (3) @(negedge clk);
    check(ev_ready === 1'b1, "R10 reset ev_ready", int'(ev_ready), 1);
    check(out_valid === 1'b0, "R10 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;

    // R10: reset pedestals 0 and threshold 0 -> all channels pass with 0 (R5)
    run_event(0, 0, 0, 0, 0, "R10 R5");

    // R7: nothing survives, marker only
    for (int k = 0; k < NCH; k++) raw_m[k] = 10;
    write_thr(1);
    run_event(0, 0, 0, 0, 0, "R7");

    // R3 mean 31 from 31.5, with stalls (R8)
    for (int k = 0; k < NCH; k++) raw_m[k] = k % 64;
    write_thr(5);
    run_event(3, 0, 0, 0, 0, "R3 R8");

    // R3 floor: sum of -1 gives mean -1
    for (int k = 0; k < NCH; k++) begin raw_m[k] = (k * 5) % 60; write_ped(k, raw_m[k]); end
    write_ped(5, raw_m[5] + 1);
    write_thr(1);
    run_event(0, 0, 0, 0, 0, "R3 floor");

    // R2 upper saturation: 63 - (-128) clips to 127
    for (int k = 0; k < NCH; k++) begin raw_m[k] = 0; write_ped(k, 0); end
    raw_m[0] = 63; write_ped(0, -128);
    write_thr(127);
    run_event(0, 0, 0, 0, 0, "R2");

    // R4 lower saturation on the last channel
    for (int k = 0; k < NCH; k++) begin raw_m[k] = 63; write_ped(k, -64); end
    raw_m[NCH-1] = 0; write_ped(NCH-1, 127);
    write_thr(100);
    run_event(0, 0, 0, 0, 0, "R4");

    // varied pedestals across the whole signed range
    for (int k = 0; k < NCH; k++) begin raw_m[k] = (k * 13) % 64; write_ped(k, ((k * 37) % 256) - 128); end
    write_thr(20);
    run_event(2, 0, 0, 0, 0, "R2 R4");

    // R9: writes at acceptance and during the scan are not seen by that event
    for (int k = 0; k < NCH; k++) begin raw_m[k] = k % 64; write_ped(k, 0); end
    write_thr(5);
    run_event(0, 1, 0, 20, 0, "R9 at accept");
    run_event(0, 0, 0, 0, 0, "R9 next event");
    run_event(4, 2, 1, -5, 3, "R9 mid scan");
    run_event(0, 0, 0, 0, 0, "R9 after scan write");

    // R5: exhaustive threshold sweep
    for (int k = 0; k < NCH; k++) begin raw_m[k] = (k * 29) % 64; write_ped(k, (k % 9) - 4); end
    for (int t = 0; t < 128; t++) begin
      write_thr(t);
      run_event((t % 3 == 0) ? 5 : 0, 0, 0, 0, 0, "R5 sweep");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule